// File: doc/BRIEF.md
# Two-Register Single-Cycle Processor Core

This block is a compact 8-bit processor that completes one instruction on every rising clock edge. The instruction byte comes from a local instruction store addressed by the program counter, is split into fields by a decoder, and updates either the program counter alone or one of the two general-purpose registers. An arithmetic unit provides AND, OR, ADD and SUB between registers. A load fetches a byte from a small 16-entry data store. A conditional branch compares register 0 with register 1.

Both stores are written through dedicated load ports, normally while reset is held. Execution starts at address 0 once reset drops. The program counter and both registers are brought out on debug outputs so that a program's progress can be observed cycle by cycle.

The decoder sorts each byte into one of five instruction classes: NOP, ALU, LOAD, ORI and BRANCH. These act as the core's per-cycle states. The program counter has two transitions. STEP moves it to PC + 1 and is taken by every class, including BRANCH when the two registers differ. JUMP moves it to PC + 1 + offset and is taken by BRANCH when the registers are equal. The counter wraps modulo 256.

Top module: `duo_reg_cpu`

## Requirements
- R1: A synchronous active-high reset clears the program counter and both registers to 0 at the next rising edge.
- R2: The byte 0x00, and every byte whose bits 7..5 are 000, 011, 100 or 110, leaves both registers unchanged and moves the PC to PC + 1.
- R3: A byte with bits 7..5 = 001 writes register[bit 2] with register[bit 1] op register[bit 0]. The operation is chosen by bits 4..3: 00 AND, 01 OR, 10 ADD, 11 SUB (first source minus second).
- R4: ADD and SUB results wrap modulo 256, and no flags are produced.
- R5: A byte with bits 7..5 = 010 writes register[bit 4] with the data store byte at the zero-extended address in bits 3..0.
- R6: A byte with bits 7..5 = 101 writes register[bit 4] with its own value ORed with the zero-extended bits 3..0.
- R7: A byte with bits 7..5 = 111 sets the next PC to PC + 1 + sign-extended bits 4..0 when register 0 equals register 1, and to PC + 1 otherwise. Registers are unchanged.
- R8: Every operand read and the branch comparison use register values from before the edge that writes the result, so a register may be both source and destination.
- R9: Fetch is combinational at the current PC. A PC at or beyond the instruction store depth reads 0x00 and so acts as a no-operation.
- R10: The PC is 8 bits wide and every update wraps modulo 256, so a branch below address 0 lands near 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_wr_en | input | 1 | Write strobe for the instruction store |
| imem_wr_addr | input | 8 | Instruction store write address |
| imem_wr_data | input | 8 | Instruction byte to store |
| dmem_wr_en | input | 1 | Write strobe for the data store |
| dmem_wr_addr | input | 4 | Data store write address |
| dmem_wr_data | input | 8 | Data byte to store |
| dbg_pc | output | 8 | Current program counter |
| dbg_r0 | output | 8 | Register 0 |
| dbg_r1 | output | 8 | Register 1 |

## Verification
The bench builds the core with the default instruction store depth of 64 and the fixed 16-byte data store. With a depth of 64 the PC can be pushed past the end of the store by a backward branch from address 0. That reaches the wrap to 255 and the zero-fetch rule together. Address 63 holds a non-zero byte, so an implementation that folds 255 onto 63 changes a register and is caught. The 16-byte data store is covered at both ends by loads from addresses 0 and 15.

// File: rtl/duo_cpu_pkg.sv
package duo_cpu_pkg;

    localparam int WORD_W  = 8;
    localparam int PC_W    = 8;
    localparam int REG_CNT = 2;
    localparam int REG_AW  = 1;
    localparam int IMM_W   = 4;
    localparam int OFF_W   = 5;

    typedef enum logic [2:0] {
        K_NOP,
        K_ALU,
        K_LOAD,
        K_ORI,
        K_BRANCH
    } instr_kind_e;

    typedef enum logic [1:0] {
        ALU_AND = 2'b00,
        ALU_OR  = 2'b01,
        ALU_ADD = 2'b10,
        ALU_SUB = 2'b11
    } alu_op_e;

    typedef struct packed {
        instr_kind_e             kind;
        alu_op_e                 op;
        logic [REG_AW-1:0]       dst;
        logic [REG_AW-1:0]       sel_a;
        logic [REG_AW-1:0]       sel_b;
        logic [IMM_W-1:0]        imm;
        logic [OFF_W-1:0]        off;
    } dec_t;

endpackage

// File: rtl/duo_cpu_mem.sv
module duo_cpu_mem #(
    parameter int W      = 8,
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [W-1:0]      wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [W-1:0]      rdata
);

    logic [W-1:0] store [DEPTH];

    generate
        if (DEPTH < (1 << ADDR_W)) begin : g_partial
            always_ff @(posedge clk) begin
                if (we && (waddr < ADDR_W'(DEPTH)))
                    store[waddr[IDX_W-1:0]] <= wdata;
            end
            always_comb begin
                if (raddr < ADDR_W'(DEPTH))
                    rdata = store[raddr[IDX_W-1:0]];
                else
                    rdata = '0;
            end
        end else begin : g_full
            always_ff @(posedge clk) begin
                if (we)
                    store[waddr[IDX_W-1:0]] <= wdata;
            end
            assign rdata = store[raddr[IDX_W-1:0]];
        end
    endgenerate

endmodule

// File: rtl/duo_cpu_decode.sv
module duo_cpu_decode
    import duo_cpu_pkg::*;
(
    input  logic [WORD_W-1:0] instr,
    output dec_t              dec,
    output logic              reg_we
);

    always_comb begin
        dec.kind  = K_NOP;
        dec.op    = ALU_AND;
        dec.dst   = '0;
        dec.sel_a = '0;
        dec.sel_b = '0;
        dec.imm   = instr[IMM_W-1:0];
        dec.off   = instr[OFF_W-1:0];
        unique case (instr[7:5])
            3'b001: begin
                dec.kind  = K_ALU;
                dec.op    = alu_op_e'(instr[4:3]);
                dec.dst   = instr[2];
                dec.sel_a = instr[1];
                dec.sel_b = instr[0];
            end
            3'b010: begin
                dec.kind = K_LOAD;
                dec.dst  = instr[4];
            end
            3'b101: begin
                dec.kind  = K_ORI;
                dec.dst   = instr[4];
                dec.sel_a = instr[4];
            end
            3'b111: begin
                dec.kind  = K_BRANCH;
                dec.sel_a = 1'b0;
                dec.sel_b = 1'b1;
            end
            default: begin
                dec.kind = K_NOP;
            end
        endcase
    end

    assign reg_we = (dec.kind == K_ALU) || (dec.kind == K_LOAD) || (dec.kind == K_ORI);

endmodule

// File: rtl/duo_cpu_alu.sv
module duo_cpu_alu
    import duo_cpu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    always_comb begin
        unique case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/duo_cpu_regfile.sv
module duo_cpu_regfile #(
    parameter int W  = 8,
    parameter int N  = 2,
    localparam int AW = (N > 1) ? $clog2(N) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [AW-1:0]  waddr,
    input  logic [W-1:0]   wdata,
    input  logic [AW-1:0]  ra_addr,
    input  logic [AW-1:0]  rb_addr,
    output logic [W-1:0]   ra_data,
    output logic [W-1:0]   rb_data,
    output logic [N*W-1:0] flat
);

    logic [W-1:0] regs [N];

    generate
        for (genvar g = 0; g < N; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    regs[g] <= '0;
                else if (we && (waddr == AW'(g)))
                    regs[g] <= wdata;
            end
            assign flat[g*W +: W] = regs[g];
        end
    endgenerate

    assign ra_data = regs[ra_addr];
    assign rb_data = regs[rb_addr];

    // R2: with no write strobe, every register keeps its value
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(flat));

endmodule

// File: rtl/duo_reg_cpu.sv
module duo_reg_cpu
    import duo_cpu_pkg::*;
#(
    parameter int IMEM_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              imem_wr_en,
    input  logic [PC_W-1:0]   imem_wr_addr,
    input  logic [WORD_W-1:0] imem_wr_data,
    input  logic              dmem_wr_en,
    input  logic [IMM_W-1:0]  dmem_wr_addr,
    input  logic [WORD_W-1:0] dmem_wr_data,
    output logic [PC_W-1:0]   dbg_pc,
    output logic [WORD_W-1:0] dbg_r0,
    output logic [WORD_W-1:0] dbg_r1
);

    localparam int DMEM_DEPTH = 1 << IMM_W;

    logic [PC_W-1:0]           pc_q;
    logic [PC_W-1:0]           pc_d;
    logic [WORD_W-1:0]         instr;
    dec_t                      dec;
    logic                      reg_we;
    logic [WORD_W-1:0]         rd_a;
    logic [WORD_W-1:0]         rd_b;
    logic [WORD_W-1:0]         alu_y;
    logic [WORD_W-1:0]         dm_data;
    logic [WORD_W-1:0]         wb_data;
    logic [WORD_W-1:0]         imm_ext;
    logic [PC_W-1:0]           off_ext;
    logic                      regs_equal;
    logic [REG_CNT*WORD_W-1:0] regs_flat;

    duo_cpu_mem #(.W(WORD_W), .DEPTH(IMEM_DEPTH), .ADDR_W(PC_W)) i_imem (
        .clk   (clk),
        .we    (imem_wr_en),
        .waddr (imem_wr_addr),
        .wdata (imem_wr_data),
        .raddr (pc_q),
        .rdata (instr)
    );

    duo_cpu_decode i_dec (
        .instr  (instr),
        .dec    (dec),
        .reg_we (reg_we)
    );

    duo_cpu_regfile #(.W(WORD_W), .N(REG_CNT)) i_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .waddr   (dec.dst),
        .wdata   (wb_data),
        .ra_addr (dec.sel_a),
        .rb_addr (dec.sel_b),
        .ra_data (rd_a),
        .rb_data (rd_b),
        .flat    (regs_flat)
    );

    duo_cpu_alu #(.W(WORD_W)) i_alu (
        .op (dec.op),
        .a  (rd_a),
        .b  (rd_b),
        .y  (alu_y)
    );

    duo_cpu_mem #(.W(WORD_W), .DEPTH(DMEM_DEPTH), .ADDR_W(IMM_W)) i_dmem (
        .clk   (clk),
        .we    (dmem_wr_en),
        .waddr (dmem_wr_addr),
        .wdata (dmem_wr_data),
        .raddr (dec.imm),
        .rdata (dm_data)
    );

    assign imm_ext    = {{(WORD_W-IMM_W){1'b0}}, dec.imm};
    assign off_ext    = {{(PC_W-OFF_W){dec.off[OFF_W-1]}}, dec.off};
    assign regs_equal = (rd_a == rd_b);

    // next-PC selection: STEP or JUMP
    always_comb begin
        pc_d = pc_q + PC_W'(1);
        unique case (dec.kind)
            K_BRANCH: begin
                if (regs_equal)
                    pc_d = pc_q + PC_W'(1) + off_ext;
            end
            default: begin
                pc_d = pc_q + PC_W'(1);
            end
        endcase
    end

    // write-back data selection per instruction class
    always_comb begin
        unique case (dec.kind)
            K_ALU:   wb_data = alu_y;
            K_LOAD:  wb_data = dm_data;
            K_ORI:   wb_data = rd_a | imm_ext;
            default: wb_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= '0;
        else
            pc_q <= pc_d;
    end

    assign dbg_pc = pc_q;
    assign dbg_r0 = regs_flat[0 +: WORD_W];
    assign dbg_r1 = regs_flat[WORD_W +: WORD_W];

    // R1: reset clears PC and registers on the following edge
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (dbg_pc == '0 && dbg_r0 == '0 && dbg_r1 == '0));

    // R2: anything but a branch advances the PC by exactly one
    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        (dec.kind != K_BRANCH) |=> (dbg_pc == $past(dbg_pc) + PC_W'(1)));

    // R7: an equal comparison moves the PC by the sign-extended offset
    p_branch_jump_r7: assert property (@(posedge clk) disable iff (rst)
        (dec.kind == K_BRANCH && dbg_r0 == dbg_r1)
        |=> (dbg_pc == $past(dbg_pc) + PC_W'(1) + $past(off_ext)));

    // R7: a branch never writes a register
    p_branch_no_write_r7: assert property (@(posedge clk) disable iff (rst)
        (dec.kind == K_BRANCH) |=> ($stable(dbg_r0) && $stable(dbg_r1)));

    // R5: a load leaves the addressed data byte in the destination
    p_load_value_r5: assert property (@(posedge clk) disable iff (rst)
        (dec.kind == K_LOAD)
        |=> (($past(dec.dst) ? dbg_r1 : dbg_r0) == $past(dm_data)));

endmodule

// File: tb/test_duo_reg_cpu.sv
`timescale 1ns/1ps
module test_duo_reg_cpu;

    typedef struct {
        logic [7:0] pc;
        logic [7:0] r0;
        logic [7:0] r1;
        string      tag;
    } step_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       imem_wr_en = 1'b0;
    logic [7:0] imem_wr_addr = '0;
    logic [7:0] imem_wr_data = '0;
    logic       dmem_wr_en = 1'b0;
    logic [3:0] dmem_wr_addr = '0;
    logic [7:0] dmem_wr_data = '0;
    logic [7:0] dbg_pc;
    logic [7:0] dbg_r0;
    logic [7:0] dbg_r1;

    int    n_checks = 0;
    int    n_fails  = 0;
    logic  live = 1'b0;
    step_t sb [$];

    always #2.5 clk = ~clk;

    duo_reg_cpu i_duo_reg_cpu (
        .clk          (clk),
        .rst          (rst),
        .imem_wr_en   (imem_wr_en),
        .imem_wr_addr (imem_wr_addr),
        .imem_wr_data (imem_wr_data),
        .dmem_wr_en   (dmem_wr_en),
        .dmem_wr_addr (dmem_wr_addr),
        .dmem_wr_data (dmem_wr_data),
        .dbg_pc       (dbg_pc),
        .dbg_r0       (dbg_r0),
        .dbg_r1       (dbg_r1)
    );

    // encoders
    function automatic logic [7:0] enc_alu(input logic [1:0] op, input logic d,
                                           input logic a, input logic b);
        return {3'b001, op, d, a, b};
    endfunction
    function automatic logic [7:0] enc_lw(input logic d, input logic [3:0] imm);
        return {3'b010, d, imm};
    endfunction
    function automatic logic [7:0] enc_ori(input logic d, input logic [3:0] imm);
        return {3'b101, d, imm};
    endfunction
    function automatic logic [7:0] enc_beq(input logic [4:0] off);
        return {3'b111, off};
    endfunction

    task automatic imem_put(input int a, input logic [7:0] v);
        imem_wr_en   = 1'b1;
        imem_wr_addr = a[7:0];
        imem_wr_data = v;
        @(negedge clk);
        imem_wr_en   = 1'b0;
    endtask

    task automatic dmem_put(input int a, input logic [7:0] v);
        dmem_wr_en   = 1'b1;
        dmem_wr_addr = a[3:0];
        dmem_wr_data = v;
        @(negedge clk);
        dmem_wr_en   = 1'b0;
    endtask

    task automatic clear_imem();
        for (int i = 0; i < 64; i++) imem_put(i, 8'h00);
    endtask

    task automatic expect_step(input logic [7:0] pc, input logic [7:0] r0,
                               input logic [7:0] r1, input string tag);
        step_t s;
        s.pc = pc; s.r0 = r0; s.r1 = r1; s.tag = tag;
        sb.push_back(s);
    endtask

    task automatic run_queued();
        rst = 1'b0;
        while (sb.size() != 0) @(negedge clk);
    endtask

    task automatic check_zero(input string tag);
        n_checks++;
        if (dbg_pc !== 8'h00 || dbg_r0 !== 8'h00 || dbg_r1 !== 8'h00) begin
            n_fails++;
            $display("FAIL %s: actual pc=%h r0=%h r1=%h expected pc=00 r0=00 r1=00",
                     tag, dbg_pc, dbg_r0, dbg_r1);
        end
    endtask

    // monitor: one executed instruction per edge, compared after the edge
    always @(posedge clk) live <= !rst;

    always @(negedge clk) begin
        if (live && sb.size() > 0) begin
            step_t e;
            e = sb.pop_front();
            n_checks++;
            if (dbg_pc !== e.pc || dbg_r0 !== e.r0 || dbg_r1 !== e.r1) begin
                n_fails++;
                $display("FAIL %s: actual pc=%h r0=%h r1=%h expected pc=%h r0=%h r1=%h",
                         e.tag, dbg_pc, dbg_r0, dbg_r1, e.pc, e.r0, e.r1);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual cycles 20000, expected run to finish earlier");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check_zero("R1 reset state");

        // ---- program A: ALU, load, OR-immediate, undefined codes
        clear_imem();
        for (int i = 0; i < 16; i++) dmem_put(i, 8'(i * 3 + 1));
        dmem_put(0, 8'h7F);
        dmem_put(15, 8'h81);
        imem_put(0,  enc_ori(1'b0, 4'h5));
        imem_put(1,  enc_ori(1'b1, 4'hA));
        imem_put(2,  enc_alu(2'b01, 1'b1, 1'b0, 1'b1));
        imem_put(3,  enc_alu(2'b10, 1'b0, 1'b1, 1'b1));
        imem_put(4,  enc_alu(2'b00, 1'b1, 1'b0, 1'b1));
        imem_put(5,  enc_alu(2'b11, 1'b0, 1'b1, 1'b0));
        imem_put(6,  enc_lw(1'b1, 4'hF));
        imem_put(7,  enc_alu(2'b10, 1'b1, 1'b1, 1'b1));
        imem_put(8,  enc_lw(1'b0, 4'h0));
        imem_put(9,  enc_ori(1'b1, 4'h1));
        imem_put(10, enc_alu(2'b11, 1'b1, 1'b1, 1'b1));
        imem_put(11, 8'h00);
        imem_put(12, 8'h65);
        imem_put(13, 8'h9F);
        imem_put(14, 8'hD3);
        imem_put(15, 8'h07);
        imem_put(16, enc_beq(5'd3));
        expect_step(8'd1,  8'h05, 8'h00, "R6 ori r0");
        expect_step(8'd2,  8'h05, 8'h0A, "R6 ori r1");
        expect_step(8'd3,  8'h05, 8'h0F, "R3 or");
        expect_step(8'd4,  8'h1E, 8'h0F, "R3 add r1+r1");
        expect_step(8'd5,  8'h1E, 8'h0E, "R3 and");
        expect_step(8'd6,  8'hF0, 8'h0E, "R4 sub wraps");
        expect_step(8'd7,  8'hF0, 8'h81, "R5 load addr 15");
        expect_step(8'd8,  8'hF0, 8'h02, "R4 R8 add wraps, self source");
        expect_step(8'd9,  8'h7F, 8'h02, "R5 load addr 0");
        expect_step(8'd10, 8'h7F, 8'h03, "R6 ori onto existing value");
        expect_step(8'd11, 8'h7F, 8'h00, "R8 sub self");
        expect_step(8'd12, 8'h7F, 8'h00, "R2 nop 00");
        expect_step(8'd13, 8'h7F, 8'h00, "R2 undefined 011");
        expect_step(8'd14, 8'h7F, 8'h00, "R2 undefined 100");
        expect_step(8'd15, 8'h7F, 8'h00, "R2 undefined 110");
        expect_step(8'd16, 8'h7F, 8'h00, "R2 undefined 000 nonzero");
        expect_step(8'd17, 8'h7F, 8'h00, "R7 branch not taken");
        run_queued();
        rst = 1'b1;
        @(negedge clk);

        // ---- program B: branch directions and offsets
        clear_imem();
        imem_put(0,  enc_beq(5'd4));
        imem_put(1,  enc_beq(5'h0F));
        imem_put(2,  enc_beq(5'h1D));
        imem_put(3,  enc_ori(1'b1, 4'h2));
        imem_put(4,  enc_beq(5'h1A));
        imem_put(5,  enc_ori(1'b0, 4'h1));
        imem_put(6,  enc_beq(5'h1C));
        imem_put(7,  enc_ori(1'b1, 4'h1));
        imem_put(8,  enc_beq(5'h18));
        imem_put(17, enc_beq(5'h10));
        expect_step(8'd5,  8'h00, 8'h00, "R7 taken +4");
        expect_step(8'd6,  8'h01, 8'h00, "R6 ori r0");
        expect_step(8'd7,  8'h01, 8'h00, "R7 not taken -4");
        expect_step(8'd8,  8'h01, 8'h01, "R6 ori r1");
        expect_step(8'd1,  8'h01, 8'h01, "R7 taken -8");
        expect_step(8'd17, 8'h01, 8'h01, "R7 taken +15");
        expect_step(8'd2,  8'h01, 8'h01, "R7 taken -16");
        expect_step(8'd0,  8'h01, 8'h01, "R7 taken -3");
        expect_step(8'd5,  8'h01, 8'h01, "R7 taken +4 again");
        expect_step(8'd6,  8'h01, 8'h01, "R6 ori no change");
        expect_step(8'd3,  8'h01, 8'h01, "R7 taken -4");
        expect_step(8'd4,  8'h01, 8'h03, "R6 ori r1 |2");
        expect_step(8'd5,  8'h01, 8'h03, "R7 not taken -6");
        run_queued();
        // R1: mid-run reset with non-zero registers
        rst = 1'b1;
        @(negedge clk);
        check_zero("R1 reset during run");

        // ---- program C: PC wrap and fetch past the store
        clear_imem();
        imem_put(0,  enc_beq(5'h1E));
        imem_put(63, enc_ori(1'b0, 4'hF));
        expect_step(8'd255, 8'h00, 8'h00, "R10 wrap below zero");
        expect_step(8'd0,   8'h00, 8'h00, "R9 fetch beyond depth is nop, R10 wrap up");
        expect_step(8'd255, 8'h00, 8'h00, "R10 wrap again");
        expect_step(8'd0,   8'h00, 8'h00, "R9 fetch beyond depth again");
        run_queued();
        rst = 1'b1;
        @(negedge clk);
        check_zero("R1 final reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule